// File: doc/BRIEF.md
# Bus-Master Takeover Sequencer

This block sits on an add-in card. It controls how the card takes the shared system bus away from the host processor and how it hands the bus back. When local logic asks for the bus, the block raises a DMA request on a channel that the system has put in cascade mode. It waits for the acknowledge and then pulls the active-low master line down. It then opens the card's address/data drivers and, one clock after that, the read/write command strobes.

Mastership ends in one of two ways. The card's own logic can signal that it is finished, or an internal hold timer expires. The timer is set from the clock frequency in MHz and a hold limit in microseconds chosen below the 15 µs point at which memory refresh would be starved. The release runs in the reverse order of entry: commands first, then drivers, then the master line, then the request. A one-clock timeout flag marks a release that the timer forced. The acknowledge input is resynchronized before use. If it is lost at any point after it was granted, the block drops straight back to idle.

Top module: `busgrab_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, drq_o=0, master_n_o=1, addr_drv_en_o=0, cmd_en_o=0 and timeout_o=0.
- R2: From idle, req_i high at a clock edge raises drq_o in the next cycle. dack_i high while idle without a request has no effect: drq_o stays 0 and master_n_o stays 1.
- R3: master_n_o goes low only after dack_i has passed the SYNC_STAGES-flop synchronizer. With dack_i raised just after the first cycle of drq_o high and SYNC_STAGES=2, master_n_o goes low in the third cycle after that.
- R4: In the first cycle with master_n_o low, addr_drv_en_o is 0. It becomes 1 in the second cycle.
- R5: cmd_en_o becomes 1 only in the third cycle of master_n_o low, exactly one cycle after addr_drv_en_o rose. It is never 1 without addr_drv_en_o=1 and master_n_o=0.
- R6: done_i high at an edge while commands are enabled starts the release. In the next cycle cmd_en_o=0 and addr_drv_en_o=1. One cycle later addr_drv_en_o=0 with master_n_o still 0. One cycle later master_n_o=1 with drq_o still 1. One cycle later drq_o=0.
- R7: With HOLD_CLKS = CLK_MHZ*HOLD_LIMIT_US, master_n_o never stays low for more than HOLD_CLKS consecutive cycles. Without done_i, commands stay enabled for exactly HOLD_CLKS-4 cycles, and the R6 release order follows.
- R8: timeout_o is 1 for exactly one cycle, the first release cycle, and only when the hold timer ended the command phase. The timer wins over a done_i that arrives in the same cycle. A release started by done_i alone leaves timeout_o at 0.
- R9: If dack_i goes low after master_n_o has fallen, the block returns to idle with all outputs inactive. With SYNC_STAGES=2 this happens in the third cycle after the drop, skipping the staged release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Local request to take the bus |
| done_i | input | 1 | Local request to give the bus back |
| dack_i | input | 1 | DMA acknowledge from the system, asynchronous |
| drq_o | output | 1 | DMA request to the cascade channel |
| master_n_o | output | 1 | Active-low bus-master line |
| addr_drv_en_o | output | 1 | Enable for the address/data drivers |
| cmd_en_o | output | 1 | Enable for the read/write command strobes |
| timeout_o | output | 1 | One-clock pulse: release forced by the hold timer |

## Verification
The bench sweeps the moment done_i arrives across every command-phase length from one cycle to past the hold limit. It therefore covers the case where done_i lands in the same cycle as timer expiry, and it checks the release order and the timeout pulse against counts computed from HOLD_CLKS. An off-by-one in the hold comparison would hold the master line for HOLD_CLKS+1 cycles or release one cycle early. A release order that was wrong would show commands or drivers still on after the master line rose. The bench also drops the acknowledge mid-transfer and raises it while idle. A design that ignored the synchronizer latency, or that reacted to an unrequested acknowledge, would move master_n_o in the wrong cycle.

// File: rtl/busgrab_pkg.sv
package busgrab_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_REQUEST = 3'd1,
      ST_GRANTED = 3'd2,
      ST_DRIVE   = 3'd3,
      ST_ACTIVE  = 3'd4,
      ST_REL_CMD = 3'd5,
      ST_REL_DRV = 3'd6,
      ST_REL_MST = 3'd7
   } grab_state_e;

endpackage

// File: rtl/busgrab_sync.sv
module busgrab_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("busgrab_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/busgrab_hold_timer.sv
module busgrab_hold_timer #(
   parameter int HOLD_CLKS = 112
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expired_o
);

   localparam int CW       = $clog2(HOLD_CLKS + 1);
   localparam int EXPIRE_AT = HOLD_CLKS - 3;

   generate
      if (HOLD_CLKS < 5) begin : g_bad_hold
         $error("busgrab_hold_timer: HOLD_CLKS must be at least 5");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (!run_i)                     cnt_q <= '0;
      else if (cnt_q != CW'(HOLD_CLKS))    cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = run_i && (cnt_q >= CW'(EXPIRE_AT));

   assert_cnt_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(HOLD_CLKS));

   assert_cnt_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/busgrab_fsm.sv
module busgrab_fsm
   import busgrab_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_i,
   input  logic        done_i,
   input  logic        dack_s_i,
   input  logic        expired_i,
   output grab_state_e state_o,
   output logic        timeout_o
);

   grab_state_e state_q, state_d;
   logic        timeout_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (req_i) state_d = ST_REQUEST;
         ST_REQUEST: if (dack_s_i) state_d = ST_GRANTED;
         ST_GRANTED: state_d = dack_s_i ? ST_DRIVE : ST_IDLE;
         ST_DRIVE:   state_d = dack_s_i ? ST_ACTIVE : ST_IDLE;
         ST_ACTIVE: begin
            if (!dack_s_i)                state_d = ST_IDLE;
            else if (expired_i || done_i) state_d = ST_REL_CMD;
         end
         ST_REL_CMD: state_d = dack_s_i ? ST_REL_DRV : ST_IDLE;
         ST_REL_DRV: state_d = dack_s_i ? ST_REL_MST : ST_IDLE;
         ST_REL_MST: state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         timeout_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         timeout_q <= (state_q == ST_ACTIVE) && dack_s_i && expired_i;
      end
   end

   assign state_o   = state_q;
   assign timeout_o = timeout_q;

   assert_enter_via_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GRANTED) |-> ($past(state_q) == ST_REQUEST));

endmodule

// File: rtl/busgrab_seq.sv
module busgrab_seq
   import busgrab_pkg::*;
#(
   parameter int CLK_MHZ       = 8,
   parameter int HOLD_LIMIT_US = 14,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic done_i,
   input  logic dack_i,
   output logic drq_o,
   output logic master_n_o,
   output logic addr_drv_en_o,
   output logic cmd_en_o,
   output logic timeout_o
);

   localparam int HOLD_CLKS = CLK_MHZ * HOLD_LIMIT_US;
   localparam int RUN_W     = $clog2(HOLD_CLKS + 1) + 1;

   generate
      if (HOLD_LIMIT_US >= 15) begin : g_bad_limit
         $error("busgrab_seq: HOLD_LIMIT_US must stay below 15");
      end
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("busgrab_seq: CLK_MHZ must be positive");
      end
   endgenerate

   grab_state_e state;
   logic        dack_s;
   logic        expired;
   logic        hold_run;

   busgrab_sync #(.STAGES(SYNC_STAGES)) u_dack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (dack_i),
      .q_o   (dack_s)
   );

   busgrab_hold_timer #(.HOLD_CLKS(HOLD_CLKS)) u_hold_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (hold_run),
      .expired_o (expired)
   );

   busgrab_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_i),
      .done_i    (done_i),
      .dack_s_i  (dack_s),
      .expired_i (expired),
      .state_o   (state),
      .timeout_o (timeout_o)
   );

   assign hold_run      = state inside {ST_GRANTED, ST_DRIVE, ST_ACTIVE, ST_REL_CMD, ST_REL_DRV};
   assign drq_o         = (state != ST_IDLE);
   assign master_n_o    = !hold_run;
   assign addr_drv_en_o = state inside {ST_DRIVE, ST_ACTIVE, ST_REL_CMD};
   assign cmd_en_o      = (state == ST_ACTIVE);

   // Length of the current low stretch on the master line.
   logic [RUN_W-1:0] low_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          low_run_q <= '0;
      else if (master_n_o) low_run_q <= '0;
      else                 low_run_q <= low_run_q + 1'b1;
   end

   assert_hold_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !master_n_o |-> (low_run_q < RUN_W'(HOLD_CLKS)));

   assert_master_needs_drq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !master_n_o |-> drq_o);

   assert_master_after_dack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(master_n_o) |-> $past(dack_s));

   assert_drv_needs_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_drv_en_o) |-> $past(!master_n_o));

   assert_cmd_staged_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_en_o) |-> ($past(addr_drv_en_o) && !master_n_o));

   assert_cmd_needs_drv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_en_o |-> addr_drv_en_o);

   assert_timeout_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> ($past(cmd_en_o) && !cmd_en_o && addr_drv_en_o));

   assert_timeout_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);

endmodule

// File: tb/busgrab_seq_bench.sv
module busgrab_seq_bench;

   localparam int CLK_MHZ       = 1;
   localparam int HOLD_LIMIT_US = 14;
   localparam int H             = CLK_MHZ * HOLD_LIMIT_US;
   localparam int MAX_ACT       = H - 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_i = 1'b0;
   logic done_i = 1'b0;
   logic dack_i = 1'b0;
   logic drq_o, master_n_o, addr_drv_en_o, cmd_en_o, timeout_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   busgrab_seq #(
      .CLK_MHZ(CLK_MHZ), .HOLD_LIMIT_US(HOLD_LIMIT_US), .SYNC_STAGES(2)
   ) u_busgrab_seq (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_i(done_i), .dack_i(dack_i),
      .drq_o(drq_o), .master_n_o(master_n_o), .addr_drv_en_o(addr_drv_en_o),
      .cmd_en_o(cmd_en_o), .timeout_o(timeout_o)
   );

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic chk_all(input string tag, input logic drq, input logic mst_n,
                          input logic drv, input logic cmd, input logic to);
      chk(tag, "drq_o", drq_o, drq);
      chk(tag, "master_n_o", master_n_o, mst_n);
      chk(tag, "addr_drv_en_o", addr_drv_en_o, drv);
      chk(tag, "cmd_en_o", cmd_en_o, cmd);
      chk(tag, "timeout_o", timeout_o, to);
   endtask

   // Enter mastership; returns at the negedge of the first command cycle.
   task automatic enter_bus();
      req_i = 1'b1;
      @(negedge clk);
      chk_all("R2", 1, 1, 0, 0, 0);
      req_i  = 1'b0;
      dack_i = 1'b1;
      @(negedge clk);
      chk_all("R3", 1, 1, 0, 0, 0);
      @(negedge clk);
      chk_all("R3", 1, 1, 0, 0, 0);
      @(negedge clk);
      chk_all("R4", 1, 0, 0, 0, 0);
      @(negedge clk);
      chk_all("R5", 1, 0, 1, 0, 0);
      @(negedge clk);
      chk_all("R5", 1, 0, 1, 1, 0);
   endtask

   task automatic run_txn(input int done_after);
      int  act_len;
      logic exp_to;
      int  low_cycles;
      act_len = (done_after < MAX_ACT) ? done_after : MAX_ACT;
      exp_to  = (done_after >= MAX_ACT);
      enter_bus();
      for (int m = 1; m <= act_len; m++) begin
         chk_all("R7", 1, 0, 1, 1, 0);
         if (m == done_after) done_i = 1'b1;
         if (m != act_len) @(negedge clk);
      end
      @(negedge clk);
      done_i = 1'b0;
      chk_all(exp_to ? "R8" : "R6", 1, 0, 1, 0, exp_to);
      @(negedge clk);
      chk_all("R6", 1, 0, 0, 0, 0);
      @(negedge clk);
      chk_all("R6", 1, 1, 0, 0, 0);
      @(negedge clk);
      chk_all("R6", 0, 1, 0, 0, 0);
      low_cycles = act_len + 4;
      checks++;
      if (low_cycles > H) begin
         errors++;
         $display("FAIL R7 low cycles: actual %0d expected <= %0d", low_cycles, H);
      end
      dack_i = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      chk_all("R1", 0, 1, 0, 0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1", 0, 1, 0, 0, 0);

      // R2: acknowledge while idle and unrequested does nothing
      dack_i = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk_all("R2", 0, 1, 0, 0, 0);
      end
      dack_i = 1'b0;
      repeat (3) @(negedge clk);

      // R6/R7/R8: sweep the release point across the whole hold window
      for (int d = 1; d <= H; d++) run_txn(d);

      // R9: acknowledge lost during the command phase
      enter_bus();
      dack_i = 1'b0;
      @(negedge clk);
      chk_all("R9", 1, 0, 1, 1, 0);
      @(negedge clk);
      chk_all("R9", 1, 0, 1, 1, 0);
      @(negedge clk);
      chk_all("R9", 0, 1, 0, 0, 0);
      repeat (2) @(negedge clk);

      // R9: acknowledge lost in the first master cycle
      req_i = 1'b1;
      @(negedge clk);
      req_i  = 1'b0;
      dack_i = 1'b1;
      repeat (3) @(negedge clk);
      chk_all("R4", 1, 0, 0, 0, 0);
      dack_i = 1'b0;
      @(negedge clk);
      chk_all("R9", 1, 0, 1, 0, 0);
      @(negedge clk);
      chk_all("R9", 1, 0, 1, 1, 0);
      @(negedge clk);
      chk_all("R9", 0, 1, 0, 0, 0);
      repeat (3) @(negedge clk);

      // one more ordinary transfer after the aborts
      run_txn(3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule